// File: doc/BRIEF.md
# Program/Data Address Map Decoder for Shared Nonvolatile RAM

This block takes one memory request at a time from a processor core: an access type (instruction fetch, data read, data write) and a 16-bit address. It decides where the access goes: one of two on-board SRAM banks, a 16K real-time-clock window, or the external expansion bus. It returns the chip enables, a write qualifier and the translated SRAM address. The configuration inputs are sampled together with each accepted request, so a change to the boundary or to a mode bit applies from the next accepted request onward.

In flat mode, program space and data space each get their own 64K SRAM bank. In split mode, one shared RAM holds both. Program code sits below a movable boundary, which is aligned to 2K, and data sits at or above it. Data writes into the program part are refused and flagged. Instruction fetches are never sent off-board.

Requests enter on a valid/ready stream and leave through one register stage, also valid/ready. The input is accepted when `in_ready` is high, and `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every result output holds its value and no new request is taken. A build-time switch covers the largest memory configuration, where split mode does not exist.

Top module: `nvram_addr_map`

## Requirements
- R1: After reset, `out_valid` and `wp_violation` are 0 until a request is accepted.
- R2: In flat mode (`part_off`=1), a fetch enables bank 0 (`out_sram_ce`=2'b01) with `out_sram_addr`={0,addr}. A data access enables bank 1 (2'b10) with `out_sram_addr`={1,addr}. A write sets `out_wr_en` at any address.
- R3: In split mode (`part_off`=0), let blk=addr[15:11] and eff=min(`bound_blk`, TOP_BLKS). A fetch with blk<eff enables bank 0 with `out_sram_addr`={0,addr}. Any other fetch sets `out_fetch_fault` and asserts no enable.
- R4: In split mode, a data access with blk>=TOP_BLKS sets `out_ext_req`, and `out_wr_en` equals the write bit. A data access with blk<TOP_BLKS that is not blocked enables bank 0 with `out_sram_addr`={0,addr}. At most one of the two SRAM enables, `out_rtc_ce`, `out_ext_req` and `out_fetch_fault` is high.
- R5: In split mode, a data write with blk<eff is blocked. No enable is asserted, `out_wr_en` is 0, and `wp_violation` is high for exactly the one cycle in which that result first appears.
- R6: A fetch never sets `out_ext_req`.
- R7: With `periph_sel`=1, a data access with addr[15:14]=RTC_WIN sets only `out_rtc_ce`, in either mode and never blocked, and `out_wr_en` equals the write bit. Fetches are unaffected.
- R8: With LARGE_MEM=1, the block behaves as in flat mode whatever `part_off` is.
- R9: `in_ready` = !`out_valid` || `out_ready`. A stalled result keeps every output stable until it is taken.
- R10: Access code 2'b11 (idle) gives a valid result with all enables, the fault, `out_wr_en` and the violation at 0.
- R11: Access codes are 2'b00 fetch, 2'b01 data read, 2'b10 data write. `out_sram_addr` is 0 whenever no SRAM enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| part_off | input | 1 | 1 = flat mode, 0 = split mode |
| bound_blk | input | 5 | Program/data boundary in 2K blocks |
| periph_sel | input | 1 | Map clock window into data space |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle when high with in_valid |
| in_acc | input | 2 | Access type |
| in_addr | input | 16 | Request address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with out_valid |
| out_sram_ce | output | 2 | SRAM bank enables (bit0 program/shared, bit1 data) |
| out_rtc_ce | output | 1 | Clock window enable |
| out_ext_req | output | 1 | Expansion bus request |
| out_fetch_fault | output | 1 | Refused fetch |
| out_wr_en | output | 1 | Write strobe qualifier for the selected target |
| out_sram_addr | output | 17 | Translated SRAM address |
| wp_violation | output | 1 | One-cycle pulse on a blocked write |

## Verification
On every cycle, the assertions check four properties: the targets exclude one another, a fetch never reaches the expansion bus, a blocked write carries neither a strobe nor an enable, and a stalled result stays stable. They also check that the large-memory build never faults or goes off-board. Only the bench's sweeps can show that each block lands in the right bank at the right translated address, for every boundary, mode, window setting and access code. The bench's stall scenario shows that the violation pulse lasts one cycle.

// File: rtl/nvm_map_pkg.sv
package nvm_map_pkg;
  localparam int ADDR_W = 16;
  localparam int BLK_W  = 5;
  localparam int SADDR_W = ADDR_W + 1;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_DRD   = 2'b01,
    ACC_DWR   = 2'b10,
    ACC_IDLE  = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0]         ce;
    logic               rtc;
    logic               ext;
    logic               fault;
    logic               wr;
    logic               blocked;
    logic [SADDR_W-1:0] saddr;
    acc_e               acc;
  } map_res_t;
endpackage

// File: rtl/nvm_bound_cmp.sv
module nvm_bound_cmp #(
  parameter int BLK_W    = 5,
  parameter int TOP_BLKS = 16
) (
  input  logic [BLK_W-1:0] blk,
  input  logic [BLK_W-1:0] bound,
  output logic             below_bound,
  output logic             in_ram
);
  localparam int CW = BLK_W + 1;
  localparam logic [CW-1:0] TOP_C = CW'(TOP_BLKS);

  logic [CW-1:0] bound_w, eff, blk_w;

  always_comb begin
    bound_w     = {1'b0, bound};
    blk_w       = {1'b0, blk};
    eff         = (bound_w > TOP_C) ? TOP_C : bound_w;
    below_bound = (blk_w < eff);
    in_ram      = (blk_w < TOP_C);
  end

  // Program region is always inside the shared RAM (R3)
  always_comb begin
    if (below_bound) assert_prog_in_ram_R3: assert (in_ram);
  end
endmodule

// File: rtl/nvm_region_dec.sv
module nvm_region_dec
  import nvm_map_pkg::*;
#(
  parameter int          TOP_BLKS = 16,
  parameter logic [1:0]  RTC_WIN  = 2'b00
) (
  input  logic              flat,
  input  logic [BLK_W-1:0]  bound,
  input  logic              periph_sel,
  input  acc_e              acc,
  input  logic [ADDR_W-1:0] addr,
  output map_res_t          res
);
  localparam int SHIFT = ADDR_W - BLK_W;

  logic below_bound, in_ram, is_data, is_wr, in_win;

  nvm_bound_cmp #(.BLK_W(BLK_W), .TOP_BLKS(TOP_BLKS)) u_cmp (
    .blk         (addr[ADDR_W-1:SHIFT]),
    .bound       (bound),
    .below_bound (below_bound),
    .in_ram      (in_ram)
  );

  always_comb begin
    is_data = (acc == ACC_DRD) || (acc == ACC_DWR);
    is_wr   = (acc == ACC_DWR);
    in_win  = periph_sel && (addr[ADDR_W-1:ADDR_W-2] == RTC_WIN);

    res         = '0;
    res.acc     = acc;
    if (acc == ACC_IDLE) begin
      res.ce = 2'b00;
    end else if (is_data && in_win) begin
      res.rtc = 1'b1;
      res.wr  = is_wr;
    end else if (flat) begin
      res.ce    = is_data ? 2'b10 : 2'b01;
      res.saddr = {is_data, addr};
      res.wr    = is_wr;
    end else if (!is_data) begin
      if (below_bound) begin
        res.ce    = 2'b01;
        res.saddr = {1'b0, addr};
      end else begin
        res.fault = 1'b1;
      end
    end else if (!in_ram) begin
      res.ext = 1'b1;
      res.wr  = is_wr;
    end else if (is_wr && below_bound) begin
      res.blocked = 1'b1;
    end else begin
      res.ce    = 2'b01;
      res.saddr = {1'b0, addr};
      res.wr    = is_wr;
    end
  end
endmodule

// File: rtl/nvm_out_stage.sv
module nvm_out_stage
  import nvm_map_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  map_res_t in_res,
  output logic     out_valid,
  input  logic     out_ready,
  output map_res_t out_res,
  output logic     viol_pulse
);
  logic fire;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_res    <= '0;
      viol_pulse <= 1'b0;
    end else begin
      viol_pulse <= fire && in_res.blocked;
      if (fire) begin
        out_valid <= 1'b1;
        out_res   <= in_res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res));

  assert_viol_nowr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> out_valid && !out_res.wr && (out_res.ce == 2'b00));
endmodule

// File: rtl/nvram_addr_map.sv
module nvram_addr_map
  import nvm_map_pkg::*;
#(
  parameter int         TOP_BLKS  = 16,
  parameter logic [1:0] RTC_WIN   = 2'b00,
  parameter bit         LARGE_MEM = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         part_off,
  input  logic [4:0]   bound_blk,
  input  logic         periph_sel,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_acc,
  input  logic [15:0]  in_addr,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [1:0]   out_sram_ce,
  output logic         out_rtc_ce,
  output logic         out_ext_req,
  output logic         out_fetch_fault,
  output logic         out_wr_en,
  output logic [16:0]  out_sram_addr,
  output logic         wp_violation
);
  logic     flat;
  map_res_t dec_res, held;

  generate
    if (LARGE_MEM) begin : g_flat_only
      assign flat = 1'b1;
    end else begin : g_selectable
      assign flat = part_off;
    end
  endgenerate

  nvm_region_dec #(.TOP_BLKS(TOP_BLKS), .RTC_WIN(RTC_WIN)) u_dec (
    .flat       (flat),
    .bound      (bound_blk),
    .periph_sel (periph_sel),
    .acc        (acc_e'(in_acc)),
    .addr       (in_addr),
    .res        (dec_res)
  );

  nvm_out_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_res     (dec_res),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_res    (held),
    .viol_pulse (wp_violation)
  );

  assign out_sram_ce     = held.ce;
  assign out_rtc_ce      = held.rtc;
  assign out_ext_req     = held.ext;
  assign out_fetch_fault = held.fault;
  assign out_wr_en       = held.wr;
  assign out_sram_addr   = held.saddr;

  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_sram_ce, out_rtc_ce, out_ext_req, out_fetch_fault}));

  assert_no_ext_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (held.acc == ACC_FETCH) |-> !out_ext_req);

  assert_addr_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_sram_ce == 2'b00) |-> (out_sram_addr == 17'd0));

  generate
    if (LARGE_MEM) begin : g_chk_flat
      assert_flat_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (held.acc != ACC_IDLE) && !out_rtc_ce |-> (out_sram_ce != 2'b00));
    end
  endgenerate
endmodule

// File: tb/tb_nvram_addr_map.sv
module tb_nvram_addr_map;
  localparam int TOP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic part_off = 1'b0, periph_sel = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [4:0] bound_blk = '0;
  logic [1:0] in_acc = 2'b11;
  logic [15:0] in_addr = '0;

  logic in_ready, out_valid, out_rtc_ce, out_ext_req, out_fetch_fault, out_wr_en, wp_violation;
  logic [1:0] out_sram_ce;
  logic [16:0] out_sram_addr;
  logic b_in_ready, b_out_valid, b_rtc, b_ext, b_fault, b_wr, b_viol;
  logic [1:0] b_ce;
  logic [16:0] b_saddr;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  nvram_addr_map #(.TOP_BLKS(TOP), .RTC_WIN(2'b00), .LARGE_MEM(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .part_off(part_off), .bound_blk(bound_blk),
    .periph_sel(periph_sel), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_sram_ce(out_sram_ce), .out_rtc_ce(out_rtc_ce), .out_ext_req(out_ext_req),
    .out_fetch_fault(out_fetch_fault), .out_wr_en(out_wr_en),
    .out_sram_addr(out_sram_addr), .wp_violation(wp_violation));

  nvram_addr_map #(.TOP_BLKS(TOP), .RTC_WIN(2'b00), .LARGE_MEM(1'b1)) dut_big (
    .clk(clk), .rst_n(rst_n), .part_off(part_off), .bound_blk(bound_blk),
    .periph_sel(periph_sel), .in_valid(in_valid), .in_ready(b_in_ready),
    .in_acc(in_acc), .in_addr(in_addr), .out_valid(b_out_valid), .out_ready(out_ready),
    .out_sram_ce(b_ce), .out_rtc_ce(b_rtc), .out_ext_req(b_ext),
    .out_fetch_fault(b_fault), .out_wr_en(b_wr),
    .out_sram_addr(b_saddr), .wp_violation(b_viol));

  // Packed result: {valid, ce[1:0], rtc, ext, fault, wr, saddr[16:0], viol}
  function automatic logic [24:0] model(input logic off, input logic [4:0] bnd,
                                        input logic ps, input logic [1:0] acc,
                                        input logic [15:0] a);
    logic [1:0] ce; logic rtc, ext, flt, wr, viol; logic [16:0] sa;
    int blk, eff;
    logic dat;
    ce = 0; rtc = 0; ext = 0; flt = 0; wr = 0; viol = 0; sa = 0;
    blk = int'(a[15:11]);
    eff = (int'(bnd) > TOP) ? TOP : int'(bnd);
    dat = (acc == 2'b01) || (acc == 2'b10);
    if (acc == 2'b11) begin
    end else if (dat && ps && a[15:14] == 2'b00) begin
      rtc = 1; wr = (acc == 2'b10);
    end else if (off) begin
      ce = dat ? 2'b10 : 2'b01; sa = {dat, a}; wr = (acc == 2'b10);
    end else if (!dat) begin
      if (blk < eff) begin ce = 2'b01; sa = {1'b0, a}; end
      else flt = 1;
    end else if (blk >= TOP) begin
      ext = 1; wr = (acc == 2'b10);
    end else if (acc == 2'b10 && blk < eff) begin
      viol = 1;
    end else begin
      ce = 2'b01; sa = {1'b0, a}; wr = (acc == 2'b10);
    end
    return {1'b1, ce, rtc, ext, flt, wr, sa, viol};
  endfunction

  task automatic check(input string req, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (off=%0b bnd=%0d ps=%0b acc=%0d addr=%h)",
               req, act, exp, part_off, bound_blk, periph_sel, in_acc, in_addr);
    end
  endtask

  function automatic string tag_of(input logic off, input logic ps, input logic [1:0] acc,
                                   input logic [15:0] a);
    if (acc == 2'b11) return "R10";
    if (ps && acc != 2'b00 && a[15:14] == 2'b00) return "R7";
    if (off) return "R2";
    if (acc == 2'b00) return "R3_R6";
    if (acc == 2'b10) return "R5";
    return "R4";
  endfunction

  task automatic xact(input logic off, input logic [4:0] bnd, input logic ps,
                      input logic [1:0] acc, input logic [15:0] a);
    @(negedge clk);
    part_off = off; bound_blk = bnd; periph_sel = ps; in_acc = acc; in_addr = a;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag_of(off, ps, acc, a),
          {out_valid, out_sram_ce, out_rtc_ce, out_ext_req, out_fetch_fault, out_wr_en,
           out_sram_addr, wp_violation}, model(off, bnd, ps, acc, a));
    check("R8", {b_out_valid, b_ce, b_rtc, b_ext, b_fault, b_wr, b_saddr, b_viol},
          model(1'b1, bnd, ps, acc, a));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [24:0] expa, expb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {24'd0, out_valid | wp_violation}, 25'd0);
    check("R1", {24'd0, b_out_valid | b_viol}, 25'd0);

    // Sweep: every block, boundary, mode, window bit and access code (R2..R8, R10, R11)
    for (int off = 0; off < 2; off++)
      for (int ps = 0; ps < 2; ps++)
        for (int acc = 0; acc < 4; acc++)
          for (int bnd = 0; bnd < 32; bnd++)
            for (int blk = 0; blk < 32; blk++)
              xact(off[0], bnd[4:0], ps[0], acc[1:0],
                   16'((blk << 11) | ((blk * 37 + bnd * 5 + acc) & 16'h7FF)));

    // Back-pressure and one-cycle violation pulse (R9, R5)
    @(negedge clk);
    out_ready = 1'b0;
    part_off = 1'b0; bound_blk = 5'd8; periph_sel = 1'b0;
    in_acc = 2'b01; in_addr = 16'h5123; in_valid = 1'b1;
    expa = model(1'b0, 5'd8, 1'b0, 2'b01, 16'h5123);
    @(negedge clk);
    check("R9", {24'd0, in_ready}, 25'd0);
    in_acc = 2'b10; in_addr = 16'h1234;
    expb = model(1'b0, 5'd8, 1'b0, 2'b10, 16'h1234);
    repeat (2) @(negedge clk);
    check("R9", {out_valid, out_sram_ce, out_rtc_ce, out_ext_req, out_fetch_fault, out_wr_en,
                 out_sram_addr, wp_violation}, expa);
    check("R9", {24'd0, in_ready}, 25'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5", {out_valid, out_sram_ce, out_rtc_ce, out_ext_req, out_fetch_fault, out_wr_en,
                 out_sram_addr, wp_violation}, expb);
    @(negedge clk);
    check("R5", {24'd0, wp_violation}, 25'd0);
    check("R9", {24'd0, out_valid}, 25'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule